// File: doc/BRIEF.md
# Sleep and Idle power-mode controller

This controller places a small processor subsystem into one of two low-power depths and brings it back out. Software issues a power-save request with a one-bit operand. Operand 1 selects Idle: the CPU clock stops and the peripheral clocks keep running. Operand 0 selects Sleep: the system oscillator stops, both clock domains are gated, and the fail-safe clock monitor is disabled. The regulator can optionally drop to standby. When the watchdog is enabled, it is cleared on the way into Sleep, and its low-rate oscillator is kept alive.

Three things wake the block: an individually enabled interrupt (already masked by the interrupt controller), a watchdog time-out, or a device reset. The wake pulse lasts one cycle and carries a cause code. If the regulator went to standby, a parameterised settling interval runs before the clocks return. The clock-source selection that was in force at entry is held and presented again after wake-up. A wake event that arrives during the single entry cycle cancels the entry, so no clock is ever gated.

Top module: `pm_ctrl`

## Requirements
- R1: In Run, a request (`save_req`=1) with no wake event and no device reset moves the block to one entry cycle, which reports Run status. On the next edge the block goes to Idle if `save_mode`=1 and to Sleep if `save_mode`=0.
- R2: In Idle, `cpu_clk_en`=0 while `per_clk_en`=1, `osc_en`=1 and `fscm_en`=1. In Run and in the entry cycle, all three clock enables are 1.
- R3: In Sleep, `cpu_clk_en`, `per_clk_en` and `osc_en` are all 0.
- R4: In Idle or Sleep, `irq_wake` or `wdt_timeout` ends the low-power state on the next edge. `wake_pulse` is then high for exactly one cycle. `wake_cause` is 1 for interrupt, 2 for watchdog (watchdog wins when both are present) and 3 for device reset.
- R5: `wdt_clr` is high during the entry cycle toward Sleep only when `wdt_en`=1 and no wake event or device reset is present. It is never high at any other time.
- R6: In Sleep, `lprc_en` equals `wdt_en`. In every other state it is 1.
- R7: `fscm_en` is 0 throughout Sleep and throughout Waking, and 1 otherwise.
- R8: If `vreg_keep` was 0 when the request was accepted, `vreg_stby`=1 during Sleep. A wake event then passes through Waking (status 3, clocks still gated, `osc_en`=1) for exactly SETTLE_CYC cycles before Run. If `vreg_keep` was 1, `vreg_stby` stays 0 and the wake goes straight to Run.
- R9: `clk_sel_out` follows `clk_sel_in` one cycle late while in Run. It is frozen from the accepting edge until the block is back in Run, so the first Run cycle after a wake shows the selection that was sampled at entry.
- R10: A wake event present during the entry cycle returns the block to Run with no clock gated and no wake pulse. A wake event present together with the request keeps the block in Run.
- R11: `pm_status` encodes Run=0, Idle=1, Sleep=2, Waking=3.
- R12: `dev_rst`=1 forces Run on the next edge from any state, with all clocks enabled and `vreg_stby`=0. It overrides every other input. It pulses `wake_pulse` with cause 3 when it leaves Idle or Sleep.
- R13: While `rst_n` is low, the block is in Run with all clock enables 1, `vreg_stby`=0, `wdt_clr`=0 and `wake_pulse`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| dev_rst | input | 1 | Synchronous device reset, highest priority |
| save_req | input | 1 | Power-save request strobe |
| save_mode | input | 1 | Request operand: 0 Sleep, 1 Idle |
| irq_wake | input | 1 | An enabled interrupt is pending |
| wdt_timeout | input | 1 | Watchdog time-out |
| wdt_en | input | 1 | Watchdog enabled |
| vreg_keep | input | 1 | 1 keeps the regulator active in Sleep |
| clk_sel_in | input | SEL_W | Current clock-source selection |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | System oscillator enable |
| lprc_en | output | 1 | Low-rate watchdog oscillator enable |
| fscm_en | output | 1 | Fail-safe clock monitor enable |
| vreg_stby | output | 1 | Regulator standby request |
| wdt_clr | output | 1 | Watchdog clear pulse |
| clk_sel_out | output | SEL_W | Held clock-source selection |
| pm_status | output | 2 | Run/Idle/Sleep/Waking code |
| wake_pulse | output | 1 | One-cycle wake report |
| wake_cause | output | 2 | Wake cause: 1 irq, 2 watchdog, 3 reset |

## Verification
State, status, the wake pulse and its cause, and the clock-selection hold all change on the first rising edge after the input that causes them is sampled. The clock enables, `fscm_en` and `vreg_stby` follow the state with no further delay. `wdt_clr` and `lprc_en` also depend on the present inputs, so they respond in the same cycle. The bench changes inputs at the falling edge and compares every output 1 ns later against a behavioural model. That model steps once per edge, so each expected value is checked in the cycle it is due, and a Waking interval that is one cycle long or short shows up as a status mismatch.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_ENTER, ST_IDLE, ST_SLEEP, ST_WAKING
  } pm_state_e;

  localparam logic [1:0] STAT_RUN    = 2'd0;
  localparam logic [1:0] STAT_IDLE   = 2'd1;
  localparam logic [1:0] STAT_SLEEP  = 2'd2;
  localparam logic [1:0] STAT_WAKING = 2'd3;

  localparam logic [1:0] CAUSE_NONE = 2'd0;
  localparam logic [1:0] CAUSE_IRQ  = 2'd1;
  localparam logic [1:0] CAUSE_WDT  = 2'd2;
  localparam logic [1:0] CAUSE_RST  = 2'd3;

  // status code seen at the ports; the entry cycle still reads as Run
  function automatic logic [1:0] status_of(pm_state_e s);
    case (s)
      ST_IDLE:   return STAT_IDLE;
      ST_SLEEP:  return STAT_SLEEP;
      ST_WAKING: return STAT_WAKING;
      default:   return STAT_RUN;
    endcase
  endfunction

  // watchdog outranks an interrupt when both arrive together
  function automatic logic [1:0] cause_of(logic wdt_to, logic irq);
    if (wdt_to) return CAUSE_WDT;
    if (irq)    return CAUSE_IRQ;
    return CAUSE_NONE;
  endfunction
endpackage

// File: rtl/pm_settle_timer.sv
module pm_settle_timer #(
  parameter int SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(SETTLE_CYC) + 1;
  localparam logic [CW-1:0] START = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (load)             cnt <= START;
    else if (run && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  // R8: the count never exceeds the settle window
  always_comb begin
    if (rst_n) assert_settle_bound_R8: assert (cnt <= START);
  end
endmodule

// File: rtl/pm_fsm.sv
module pm_fsm
  import pm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dev_rst,
  input  logic       save_req,
  input  logic       save_mode,
  input  logic       irq_wake,
  input  logic       wdt_timeout,
  input  logic       vreg_keep,
  input  logic       settle_done,
  output pm_state_e  state,
  output logic       mode_q,
  output logic       stby_q,
  output logic       settle_load,
  output logic       wake_pulse,
  output logic [1:0] wake_cause
);
  logic wake_evt;
  assign wake_evt = irq_wake | wdt_timeout;
  assign settle_load = (state == ST_SLEEP) && wake_evt && stby_q && !dev_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_RUN;
      mode_q     <= 1'b0;
      stby_q     <= 1'b0;
      wake_pulse <= 1'b0;
      wake_cause <= CAUSE_NONE;
    end else begin
      wake_pulse <= 1'b0;
      if (dev_rst) begin
        if (state == ST_IDLE || state == ST_SLEEP) begin
          wake_pulse <= 1'b1;
          wake_cause <= CAUSE_RST;
        end
        state <= ST_RUN;
      end else begin
        case (state)
          ST_RUN: if (save_req && !wake_evt) begin
            state  <= ST_ENTER;
            mode_q <= save_mode;
            stby_q <= !vreg_keep;
          end
          ST_ENTER: state <= wake_evt ? ST_RUN : (mode_q ? ST_IDLE : ST_SLEEP);
          ST_IDLE: if (wake_evt) begin
            state      <= ST_RUN;
            wake_pulse <= 1'b1;
            wake_cause <= cause_of(wdt_timeout, irq_wake);
          end
          ST_SLEEP: if (wake_evt) begin
            state      <= stby_q ? ST_WAKING : ST_RUN;
            wake_pulse <= 1'b1;
            wake_cause <= cause_of(wdt_timeout, irq_wake);
          end
          ST_WAKING: if (settle_done) state <= ST_RUN;
          default: state <= ST_RUN;
        endcase
      end
    end
  end

  assert_entry_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ENTER && !wake_evt && !dev_rst) |=>
      (state == (mode_q ? ST_IDLE : ST_SLEEP)));
  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);
  assert_abort_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ENTER && wake_evt) |=> (state == ST_RUN && !wake_pulse));
  assert_settle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAKING && !settle_done && !dev_rst) |=> state == ST_WAKING);
  assert_reset_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst |=> state == ST_RUN);
endmodule

// File: rtl/pm_gate_decode.sv
module pm_gate_decode
  import pm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pm_state_e state,
  input  logic      mode_q,
  input  logic      stby_q,
  input  logic      wdt_en,
  input  logic      wake_evt,
  input  logic      dev_rst,
  output logic      cpu_clk_en,
  output logic      per_clk_en,
  output logic      osc_en,
  output logic      lprc_en,
  output logic      fscm_en,
  output logic      vreg_stby,
  output logic      wdt_clr
);
  always_comb begin
    cpu_clk_en = 1'b1;
    per_clk_en = 1'b1;
    osc_en     = 1'b1;
    lprc_en    = 1'b1;
    fscm_en    = 1'b1;
    vreg_stby  = 1'b0;
    case (state)
      ST_IDLE: cpu_clk_en = 1'b0;
      ST_SLEEP: begin
        cpu_clk_en = 1'b0;
        per_clk_en = 1'b0;
        osc_en     = 1'b0;
        lprc_en    = wdt_en;
        fscm_en    = 1'b0;
        vreg_stby  = stby_q;
      end
      ST_WAKING: begin
        cpu_clk_en = 1'b0;
        per_clk_en = 1'b0;
        fscm_en    = 1'b0;
      end
      default: ;
    endcase
  end

  assign wdt_clr = (state == ST_ENTER) && !mode_q && wdt_en && !wake_evt && !dev_rst;

  assert_sleep_osc_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status_of(state) == STAT_SLEEP) |-> (!osc_en && !per_clk_en));
  assert_monitor_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_of(state) == STAT_WAKING) |-> !fscm_en);
endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pm_pkg::*;
#(
  parameter int SETTLE_CYC = 16,
  parameter int SEL_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_rst,
  input  logic             save_req,
  input  logic             save_mode,
  input  logic             irq_wake,
  input  logic             wdt_timeout,
  input  logic             wdt_en,
  input  logic             vreg_keep,
  input  logic [SEL_W-1:0] clk_sel_in,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             osc_en,
  output logic             lprc_en,
  output logic             fscm_en,
  output logic             vreg_stby,
  output logic             wdt_clr,
  output logic [SEL_W-1:0] clk_sel_out,
  output logic [1:0]       pm_status,
  output logic             wake_pulse,
  output logic [1:0]       wake_cause
);
  pm_state_e state;
  logic mode_q, stby_q, settle_load, settle_done, wake_evt;
  logic [SEL_W-1:0] sel_r;

  assign wake_evt = irq_wake | wdt_timeout;

  pm_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .dev_rst(dev_rst), .save_req(save_req),
    .save_mode(save_mode), .irq_wake(irq_wake), .wdt_timeout(wdt_timeout),
    .vreg_keep(vreg_keep), .settle_done(settle_done), .state(state),
    .mode_q(mode_q), .stby_q(stby_q), .settle_load(settle_load),
    .wake_pulse(wake_pulse), .wake_cause(wake_cause)
  );

  pm_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(settle_load),
    .run(state == ST_WAKING), .done(settle_done)
  );

  pm_gate_decode u_dec (
    .clk(clk), .rst_n(rst_n), .state(state), .mode_q(mode_q), .stby_q(stby_q),
    .wdt_en(wdt_en), .wake_evt(wake_evt), .dev_rst(dev_rst),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .lprc_en(lprc_en), .fscm_en(fscm_en), .vreg_stby(vreg_stby), .wdt_clr(wdt_clr)
  );

  // selection tracks the input only while running, frozen from entry to wake
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                sel_r <= '0;
    else if (state == ST_RUN)  sel_r <= clk_sel_in;
  end

  assign clk_sel_out = sel_r;
  assign pm_status   = status_of(state);

  assert_wdt_clear_then_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |=> pm_status == STAT_SLEEP);
  assert_sel_restored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pm_status) != STAT_RUN && pm_status == STAT_RUN) |-> $stable(clk_sel_out));
  assert_idle_gates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_status == STAT_IDLE) |-> (!cpu_clk_en && per_clk_en));
endmodule

// File: tb/pm_ctrl_tb.sv
module pm_ctrl_tb;
  localparam int SETTLE = 5;
  localparam int SW = 3;

  logic clk = 0, rst_n = 0, dev_rst = 0, save_req = 0, save_mode = 0;
  logic irq_wake = 0, wdt_timeout = 0, wdt_en = 0, vreg_keep = 1;
  logic [SW-1:0] clk_sel_in = 3'd2;
  logic cpu_clk_en, per_clk_en, osc_en, lprc_en, fscm_en, vreg_stby, wdt_clr;
  logic [SW-1:0] clk_sel_out;
  logic [1:0] pm_status, wake_cause;
  logic wake_pulse;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done_flag = 0;

  pm_ctrl #(.SETTLE_CYC(SETTLE), .SEL_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .dev_rst(dev_rst), .save_req(save_req),
    .save_mode(save_mode), .irq_wake(irq_wake), .wdt_timeout(wdt_timeout),
    .wdt_en(wdt_en), .vreg_keep(vreg_keep), .clk_sel_in(clk_sel_in),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .lprc_en(lprc_en), .fscm_en(fscm_en), .vreg_stby(vreg_stby), .wdt_clr(wdt_clr),
    .clk_sel_out(clk_sel_out), .pm_status(pm_status), .wake_pulse(wake_pulse),
    .wake_cause(wake_cause)
  );

  always #5 clk = ~clk;

  // reference model: 0 run, 1 idle, 2 sleep, 3 waking, 4 entering
  int m_st = 0, m_mode = 0, m_stby = 0, m_cnt = 0, m_sel = 0, m_pulse = 0, m_cause = 0;

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  function automatic int m_status();
    return (m_st == 4) ? 0 : m_st;
  endfunction

  always @(negedge clk) begin
    #1;
    if (!done_flag) begin
      int wake;
      wake = irq_wake | wdt_timeout;
      chk("R2 R3 cpu clock", cpu_clk_en, (m_st == 0 || m_st == 4));
      chk("R2 R3 peripheral clock", per_clk_en, (m_st == 0 || m_st == 4 || m_st == 1));
      chk("R3 oscillator", osc_en, (m_st != 2));
      chk("R6 low-rate osc", lprc_en, (m_st == 2) ? int'(wdt_en) : 1);
      chk("R7 clock monitor", fscm_en, !(m_st == 2 || m_st == 3));
      chk("R8 regulator standby", vreg_stby, (m_st == 2 && m_stby == 1));
      chk("R5 watchdog clear", wdt_clr,
          (m_st == 4 && m_mode == 0 && wdt_en && !wake && !dev_rst));
      chk("R9 clock selection", clk_sel_out, m_sel);
      chk("R1 R11 status", pm_status, m_status());
      chk("R4 R12 wake pulse", wake_pulse, m_pulse);
      if (m_pulse) chk("R4 R12 wake cause", wake_cause, m_cause);
      // advance the model by one edge
      if (!rst_n) begin
        m_st = 0; m_mode = 0; m_stby = 0; m_sel = 0; m_pulse = 0;
      end else begin
        int prev;
        prev = m_st;
        m_pulse = 0;
        if (prev == 0) m_sel = clk_sel_in;
        if (dev_rst) begin
          if (prev == 1 || prev == 2) begin m_pulse = 1; m_cause = 3; end
          m_st = 0;
        end else if (prev == 0) begin
          if (save_req && !wake) begin m_st = 4; m_mode = save_mode; m_stby = !vreg_keep; end
        end else if (prev == 4) begin
          m_st = wake ? 0 : (m_mode ? 1 : 2);
        end else if (prev == 1 || prev == 2) begin
          if (wake) begin
            m_pulse = 1;
            m_cause = wdt_timeout ? 2 : 1;
            if (prev == 2 && m_stby) begin m_st = 3; m_cnt = SETTLE; end
            else m_st = 0;
          end
        end else begin
          m_cnt--;
          if (m_cnt == 0) m_st = 0;
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic request(bit mode);
    @(negedge clk); save_req = 1; save_mode = mode;
    @(negedge clk); save_req = 0;
  endtask

  task automatic pulse_in(ref logic sig);
    @(negedge clk); sig = 1;
    @(negedge clk); sig = 0;
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 20000) begin
        n_run++; n_fail++;
        $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
        finish_run();
      end
    end
  end

  initial begin
    // R13: reset state
    tick(3);
    chk("R13 reset cpu clock", cpu_clk_en, 1);
    chk("R13 reset regulator", vreg_stby, 0);
    chk("R13 reset pulse", wake_pulse, 0);
    chk("R13 reset clear", wdt_clr, 0);
    rst_n = 1;
    tick(3);

    // R1 R2 R4: Idle entry, interrupt wake
    request(1'b1);
    tick(4);
    chk("R2 idle held", pm_status, 1);
    pulse_in(irq_wake);
    tick(2);

    // R3 R5 R6 R9: Sleep with watchdog, selection changed while asleep, watchdog wake
    wdt_en = 1; vreg_keep = 1; clk_sel_in = 3'd5;
    tick(2);
    request(1'b0);
    clk_sel_in = 3'd1;
    tick(4);
    chk("R6 lprc kept in sleep", lprc_en, 1);
    @(negedge clk); wdt_timeout = 1; irq_wake = 1;
    @(negedge clk); wdt_timeout = 0; irq_wake = 0;
    #1 chk("R9 restored selection", clk_sel_out, 5);
    tick(2);

    // R7 R8: regulator standby, settle delay, watchdog disabled
    wdt_en = 0; vreg_keep = 0;
    request(1'b0);
    tick(3);
    chk("R6 lprc off in sleep", lprc_en, 0);
    pulse_in(irq_wake);
    tick(SETTLE + 3);
    chk("R8 back to run after settle", pm_status, 0);

    // R10: wake during entry cycle, and wake with the request
    vreg_keep = 1;
    @(negedge clk); save_req = 1; save_mode = 0;
    @(negedge clk); save_req = 0; irq_wake = 1;
    @(negedge clk); irq_wake = 0;
    tick(2);
    chk("R10 aborted entry stays run", pm_status, 0);
    chk("R10 aborted entry cpu clock", cpu_clk_en, 1);
    @(negedge clk); save_req = 1; wdt_timeout = 1;
    @(negedge clk); save_req = 0; wdt_timeout = 0;
    tick(2);
    chk("R10 simultaneous wake stays run", pm_status, 0);

    // R12: device reset from sleep, from waking, and together with a request
    request(1'b0);
    tick(3);
    pulse_in(dev_rst);
    tick(2);
    vreg_keep = 0;
    request(1'b0);
    tick(2);
    pulse_in(irq_wake);
    tick(2);
    pulse_in(dev_rst);
    tick(2);
    chk("R12 reset ends waking", pm_status, 0);
    @(negedge clk); save_req = 1; dev_rst = 1;
    @(negedge clk); save_req = 0; dev_rst = 0;
    tick(3);
    chk("R12 reset overrides request", pm_status, 0);

    // R1 R2: Idle with a device reset wake
    request(1'b1);
    tick(2);
    pulse_in(dev_rst);
    tick(3);
    finish_run();
  end
endmodule